// File: doc/BRIEF.md
# PCM Time Slot Serial Port

This block moves voice samples between a codec core and a serial PCM bus. The bus is timed by a master bit clock and a frame sync that marks the start of each 8 kHz frame, so one frame lasts 125 µs. In each frame the port sends one transmit sample on the serial output, with a separate tri-state enable, and takes one receive sample from the serial input. A sample word is either 14 bits wide for linear coding or 8 bits wide for companded coding. Samples travel most significant bit first. Companding arithmetic is done elsewhere.

Three timing modes are supported. In non-delayed timing, the first bit goes out during the bit-clock period in which frame sync is high. In delayed timing, it goes out one period later. Non-delayed timing can also use reverse edges. With normal edges, data is launched on the rising bit-clock edge and sampled on the falling edge. With reverse edges, the two edges swap.

The bit clock, frame sync and serial input pass through a synchronizer into a fast local clock, which sees their edges as events. While the block is powered down, the output stays released. After a power-up it stays released until the second frame sync. If the bit clock stops, the block drops into the same released, powered-down state.

Top module: `pcm_tsp`

## Requirements
- R1: With `mode_comp`=0 the slot carries 14 bits, namely `tx_word[13:0]` sent bit 13 first. With `mode_comp`=1 the slot carries 8 bits, namely `tx_word[7:0]` sent bit 7 first.
- R2: With `mode_dly`=0, the first bit is driven on the launch edge at which frame sync is first seen high.
- R3: With `mode_dly`=1, the first bit is driven on the next launch edge after the one at which frame sync is first seen high.
- R4: The launch edge is the rising bit-clock edge and the capture edge is the falling edge, except when `mode_dly`=0 and `mode_rev`=1. In that case the launch edge is falling and the capture edge is rising. When `mode_dly`=1, `mode_rev` has no effect.
- R5: In an enabled slot, `dx_oe` is high for exactly as many launch periods as there are bits. It drops at the following launch edge. `dx` is 0 whenever `dx_oe` is 0.
- R6: After `pwr_up` goes from 0 to 1, the slot of the first frame sync leaves `dx_oe` low. Slots are driven from the second frame sync onward.
- R7: While `pwr_up`=0, `dx_oe` is low. Dropping `pwr_up` during a slot releases `dx` within a few local clock cycles and abandons the receive word.
- R8: If the bit clock shows no transition for `LOSS_LIM` local clock cycles, the port acts as powered down, as in R7. Once the clock returns, two frame syncs are again needed before `dx` is driven.
- R9: In each slot, `dr` is sampled at the capture edges that follow the slot's first launch edge, one bit per edge, MSB first. The bit count is 14 or 8, per R1. The word appears right-aligned on `rx_word`, with the upper bits 0 in 8-bit mode. `rx_valid` pulses for one local clock cycle after the last bit has been sampled. Receiving works from the first frame after power-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local sampling clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | PCM master bit clock |
| fsync | input | 1 | Frame sync, high for one bit period per frame |
| mode_dly | input | 1 | 1 selects delayed frame-sync timing |
| mode_rev | input | 1 | 1 selects reverse edges in non-delayed timing |
| mode_comp | input | 1 | 1 selects the 8-bit word, 0 the 14-bit word |
| pwr_up | input | 1 | 1 means powered up |
| tx_word | input | 14 | Transmit sample |
| dr | input | 1 | Serial receive data |
| rx_word | output | 14 | Last received word, right-aligned |
| rx_valid | output | 1 | One-cycle strobe when `rx_word` is updated |
| dx | output | 1 | Serial transmit data |
| dx_oe | output | 1 | Drive enable for `dx`; 0 means high impedance |

## Verification
Several properties hold on every cycle:
- `dx` and `dx_oe` move only after a launch event or a loss of power.
- The enable never rises before the required number of frame syncs has been counted.
- A powered-down or clock-lost port keeps `dx_oe` low.
- The receive strobe lasts a single cycle and always follows a capture event.

Other behaviour only the bench scenarios can show:
- The actual bit order of each word in each mode.
- The one-period shift of delayed timing.
- The swap of edges in reverse mode.
- The exact number of driven periods.
- The received values.
- The restart of the two-frame wait after a power cycle or a clock stop.

// File: rtl/pcm_tsp_pkg.sv
package pcm_tsp_pkg;

   // Events seen on the synchronized serial lines in one local clock cycle
   typedef struct packed {
      logic rise;   // bit clock went 0 -> 1
      logic fall;   // bit clock went 1 -> 0
      logic fs;     // synchronized frame sync level
      logic dr;     // synchronized receive data level
   } line_evt_t;

   // Word length of a slot for a given coding choice
   function automatic int slot_bits(input logic comp, input int lin_w, input int cmp_w);
      return comp ? cmp_w : lin_w;
   endfunction

endpackage

// File: rtl/pcm_tsp_sync.sv
module pcm_tsp_sync
   import pcm_tsp_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int LOSS_LIM    = 64
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      bclk,
   input  logic      fsync,
   input  logic      dr,
   output line_evt_t evt,
   output logic      lost
);
   localparam int CW = $clog2(LOSS_LIM + 1);

   logic [SYNC_STAGES-1:0][2:0] stg;
   logic [2:0]                  last;
   logic                        b_prev;
   logic [CW-1:0]               idle;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stg <= '0;
      end else begin
         stg[0] <= {bclk, fsync, dr};
         for (int i = 1; i < SYNC_STAGES; i++) begin
            stg[i] <= stg[i-1];
         end
      end
   end

   assign last = stg[SYNC_STAGES-1];

   always_ff @(posedge clk) begin
      if (!rst_n) b_prev <= 1'b0;
      else        b_prev <= last[2];
   end

   assign evt.rise = last[2] & ~b_prev;
   assign evt.fall = ~last[2] & b_prev;
   assign evt.fs   = last[1];
   assign evt.dr   = last[0];

   // Loss-of-clock watch: counts local cycles without a bit clock edge
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idle <= '0;
         lost <= 1'b0;
      end else if (evt.rise | evt.fall) begin
         idle <= '0;
         lost <= 1'b0;
      end else if (idle == CW'(LOSS_LIM)) begin
         lost <= 1'b1;
      end else begin
         idle <= idle + 1'b1;
      end
   end

   // R8: after LOSS_LIM quiet cycles the loss flag must be up
   a_r8_loss_flagged: assert property (@(posedge clk) disable iff (!rst_n)
      (idle == CW'(LOSS_LIM)) |=> (lost || $past(evt.rise | evt.fall)));

endmodule

// File: rtl/pcm_tsp_frame.sv
module pcm_tsp_frame
   import pcm_tsp_pkg::*;
#(
   parameter int FRAMES_TO_ENABLE = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  line_evt_t evt,
   input  logic      active,
   input  logic      dly,
   input  logic      rev,
   output logic      launch,
   output logic      capture,
   output logic      slot_start,
   output logic      gate,
   output logic      frames_ok
);
   localparam int FW = $clog2(FRAMES_TO_ENABLE + 1);

   logic          rev_eff;
   logic          fs_last;
   logic          fs_new;
   logic          pend;
   logic [FW-1:0] cnt;

   assign rev_eff = rev & ~dly;
   assign launch  = rev_eff ? evt.fall : evt.rise;
   assign capture = rev_eff ? evt.rise : evt.fall;
   assign fs_new  = launch & evt.fs & ~fs_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fs_last <= 1'b0;
         pend    <= 1'b0;
      end else begin
         if (launch) fs_last <= evt.fs;
         if (!active)     pend <= 1'b0;
         else if (launch) pend <= dly & fs_new;
      end
   end

   assign slot_start = active & ((fs_new & ~dly) | (launch & pend));

   // Frame syncs seen since the port became active, saturating
   always_ff @(posedge clk) begin
      if (!rst_n || !active)                            cnt <= '0;
      else if (fs_new && cnt != FW'(FRAMES_TO_ENABLE))  cnt <= cnt + 1'b1;
   end

   assign frames_ok = (cnt == FW'(FRAMES_TO_ENABLE));
   assign gate      = frames_ok | ((cnt == FW'(FRAMES_TO_ENABLE - 1)) & fs_new);

   // R3: a delayed slot starts only on the launch edge after a frame sync
   a_r3_delayed_start: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_start && dly) |-> (pend && !evt.fs || pend));

endmodule

// File: rtl/pcm_tsp_tx.sv
module pcm_tsp_tx
   import pcm_tsp_pkg::*;
#(
   parameter int LIN_W = 14,
   parameter int CMP_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             launch,
   input  logic             slot_start,
   input  logic             gate,
   input  logic             comp,
   input  logic [LIN_W-1:0] word,
   output logic             dx,
   output logic             dx_oe
);
   localparam int RW = $clog2(LIN_W + 1);

   logic [LIN_W-1:0] aligned;
   logic [LIN_W-1:0] sh;
   logic [RW-1:0]    rem;

   // Place the short word at the top so both lengths shift from one MSB
   generate
      if (CMP_W < LIN_W) begin : g_pad
         assign aligned = comp ? {word[CMP_W-1:0], {(LIN_W-CMP_W){1'b0}}} : word;
      end else begin : g_same
         assign aligned = word;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh    <= '0;
         rem   <= '0;
         dx    <= 1'b0;
         dx_oe <= 1'b0;
      end else if (!active) begin
         rem   <= '0;
         dx    <= 1'b0;
         dx_oe <= 1'b0;
      end else if (slot_start) begin
         sh    <= aligned << 1;
         dx    <= aligned[LIN_W-1] & gate;
         dx_oe <= gate;
         rem   <= RW'(slot_bits(comp, LIN_W, CMP_W) - 1);
      end else if (launch) begin
         if (rem != '0) begin
            dx  <= sh[LIN_W-1] & dx_oe;
            sh  <= sh << 1;
            rem <= rem - 1'b1;
         end else begin
            dx    <= 1'b0;
            dx_oe <= 1'b0;
         end
      end
   end

   // R7: a powered-down port releases the line on the next cycle
   a_r7_down_releases: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> !dx_oe);

   // R4: serial data moves only after a launch event or a power loss
   a_r4_dx_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dx) |-> ($past(launch) || $past(!active)));

   // R5: the enable rises only at the start of a slot
   a_r5_oe_rise_at_slot: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dx_oe) |-> $past(slot_start));

   // R5: nothing is driven while the line is released
   a_r5_quiet_released: assert property (@(posedge clk) disable iff (!rst_n)
      !dx_oe |-> !dx);

endmodule

// File: rtl/pcm_tsp_rx.sv
module pcm_tsp_rx
   import pcm_tsp_pkg::*;
#(
   parameter int LIN_W = 14,
   parameter int CMP_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             capture,
   input  logic             slot_start,
   input  logic             comp,
   input  logic             dr,
   output logic [LIN_W-1:0] rx_word,
   output logic             rx_valid
);
   localparam int RW = $clog2(LIN_W + 1);

   logic [LIN_W-1:0] sh;
   logic [RW-1:0]    rem;
   logic [LIN_W-1:0] nxt;

   assign nxt = {sh[LIN_W-2:0], dr};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh       <= '0;
         rem      <= '0;
         rx_word  <= '0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (!active) begin
            rem <= '0;
         end else if (slot_start) begin
            sh  <= '0;
            rem <= RW'(slot_bits(comp, LIN_W, CMP_W));
         end else if (capture && rem != '0) begin
            sh  <= nxt;
            rem <= rem - 1'b1;
            if (rem == RW'(1)) begin
               rx_word  <= nxt;
               rx_valid <= 1'b1;
            end
         end
      end
   end

   // R9: the strobe is one cycle wide
   a_r9_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R9: the strobe follows a capture event
   a_r9_strobe_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(capture));

endmodule

// File: rtl/pcm_tsp.sv
module pcm_tsp
   import pcm_tsp_pkg::*;
#(
   parameter int LIN_W            = 14,
   parameter int CMP_W            = 8,
   parameter int SYNC_STAGES      = 2,
   parameter int LOSS_LIM         = 64,
   parameter int FRAMES_TO_ENABLE = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bclk,
   input  logic             fsync,
   input  logic             mode_dly,
   input  logic             mode_rev,
   input  logic             mode_comp,
   input  logic             pwr_up,
   input  logic [LIN_W-1:0] tx_word,
   input  logic             dr,
   output logic [LIN_W-1:0] rx_word,
   output logic             rx_valid,
   output logic             dx,
   output logic             dx_oe
);
   generate
      if (CMP_W < 1 || CMP_W > LIN_W) begin : g_bad_width
         $error("pcm_tsp: CMP_W must lie in 1..LIN_W");
      end
      if (LIN_W < 2) begin : g_bad_lin
         $error("pcm_tsp: LIN_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pcm_tsp: SYNC_STAGES must be at least 2");
      end
      if (LOSS_LIM < 4) begin : g_bad_loss
         $error("pcm_tsp: LOSS_LIM must be at least 4");
      end
      if (FRAMES_TO_ENABLE < 1) begin : g_bad_frames
         $error("pcm_tsp: FRAMES_TO_ENABLE must be at least 1");
      end
   endgenerate

   line_evt_t evt;
   logic      lost;
   logic      active;
   logic      launch;
   logic      capture;
   logic      slot_start;
   logic      gate;
   logic      frames_ok;

   assign active = pwr_up & ~lost;

   pcm_tsp_sync #(
      .SYNC_STAGES (SYNC_STAGES),
      .LOSS_LIM    (LOSS_LIM)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .bclk  (bclk),
      .fsync (fsync),
      .dr    (dr),
      .evt   (evt),
      .lost  (lost)
   );

   pcm_tsp_frame #(
      .FRAMES_TO_ENABLE (FRAMES_TO_ENABLE)
   ) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt        (evt),
      .active     (active),
      .dly        (mode_dly),
      .rev        (mode_rev),
      .launch     (launch),
      .capture    (capture),
      .slot_start (slot_start),
      .gate       (gate),
      .frames_ok  (frames_ok)
   );

   pcm_tsp_tx #(
      .LIN_W (LIN_W),
      .CMP_W (CMP_W)
   ) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .active     (active),
      .launch     (launch),
      .slot_start (slot_start),
      .gate       (gate),
      .comp       (mode_comp),
      .word       (tx_word),
      .dx         (dx),
      .dx_oe      (dx_oe)
   );

   pcm_tsp_rx #(
      .LIN_W (LIN_W),
      .CMP_W (CMP_W)
   ) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .active     (active),
      .capture    (capture),
      .slot_start (slot_start),
      .comp       (mode_comp),
      .dr         (evt.dr),
      .rx_word    (rx_word),
      .rx_valid   (rx_valid)
   );

   // R6: the line is never enabled before enough frame syncs were counted
   a_r6_two_frames: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dx_oe) |-> frames_ok);

   // R8: a lost bit clock keeps the line released
   a_r8_lost_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      lost |=> !dx_oe);

endmodule

// File: tb/pcm_tsp_test.sv
module pcm_tsp_test;
   localparam int H    = 8;    // local clocks per bit-clock half period
   localparam int LOSS = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bclk = 1'b0;
   logic        fsync = 1'b0;
   logic        mode_dly = 1'b0;
   logic        mode_rev = 1'b0;
   logic        mode_comp = 1'b0;
   logic        pwr_up = 1'b0;
   logic [13:0] tx_word = '0;
   logic        dr = 1'b0;
   logic [13:0] rx_word;
   logic        rx_valid;
   logic        dx;
   logic        dx_oe;

   int n_checks = 0;
   int n_errors = 0;
   int rx_cnt   = 0;
   logic [13:0] rx_got = '0;
   bit done = 0;

   always #2 clk = ~clk;   // 250 MHz

   pcm_tsp #(.LOSS_LIM(LOSS)) uut (
      .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync),
      .mode_dly(mode_dly), .mode_rev(mode_rev), .mode_comp(mode_comp),
      .pwr_up(pwr_up), .tx_word(tx_word), .dr(dr),
      .rx_word(rx_word), .rx_valid(rx_valid), .dx(dx), .dx_oe(dx_oe)
   );

   always @(posedge clk) begin
      if (rx_valid) begin
         rx_cnt <= rx_cnt + 1;
         rx_got <= rx_word;
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // One bit-clock half period with a line check in its settled part
   task automatic half(input logic lvl, input logic fs, input logic d,
                       input logic e_oe, input logic e_dx, input string req);
      @(negedge clk);
      bclk  = lvl;
      fsync = fs;
      dr    = d;
      repeat (6) @(negedge clk);
      check(req, "dx_oe", int'(dx_oe), int'(e_oe));
      check(req, "dx", int'(dx), int'(e_dx));
      repeat (H - 7) @(negedge clk);
   endtask

   // Reference model of one frame: two idle periods, then 20 periods from frame sync.
   // cut_kind 1 drops power at period cut_at, 2 stops the bit clock there.
   task automatic run_frame(input int w, input bit dly, input bit rev, input bit comp,
                            input logic [13:0] txw, input logic [13:0] rxw,
                            input bit gate, input int cut_at, input int cut_kind,
                            input string req);
      logic llvl;
      int   first;
      bit   alive;
      logic [13:0] mask;
      @(negedge clk);
      mode_dly  = dly;
      mode_rev  = rev;
      mode_comp = comp;
      tx_word   = txw;
      llvl  = (rev && !dly) ? 1'b0 : 1'b1;
      first = dly ? 1 : 0;
      alive = 1;
      mask  = 14'((1 << w) - 1);
      rx_cnt = 0;
      for (int p = -2; p < 20; p++) begin
         bit   inslot;
         int   k;
         logic tb, rb, eoe;
         if (p == cut_at) begin
            if (cut_kind == 1) begin
               @(negedge clk);
               pwr_up = 1'b0;
               repeat (3) @(negedge clk);
               check("R7", "dx_oe after power down", int'(dx_oe), 0);
            end else begin
               repeat (3 * LOSS + 8) @(negedge clk);
               check("R8", "dx_oe after clock loss", int'(dx_oe), 0);
            end
            alive = 0;
         end
         inslot = (p >= first) && (p < first + w);
         k   = p - first;
         tb  = inslot ? txw[w - 1 - k] : 1'b0;
         rb  = inslot ? rxw[w - 1 - k] : 1'b0;
         eoe = inslot && gate && alive;
         half(llvl,  (p == 0), rb, eoe, eoe & tb, req);
         half(~llvl, (p == 0), rb, eoe, eoe & tb, req);
      end
      repeat (2) @(negedge clk);
      check("R9", "rx strobes", rx_cnt, alive ? 1 : 0);
      if (alive) check("R9", "rx word", int'(rx_got), int'(rxw & mask));
   endtask

   initial begin
      repeat (10) @(negedge clk);
      check("R7", "reset dx_oe", int'(dx_oe), 0);
      check("R9", "reset rx_valid", int'(rx_valid), 0);
      rst_n = 1'b1;
      repeat (4) begin
         half(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
         half(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
      end
      @(negedge clk);
      pwr_up = 1'b1;
      // R6: first frame after power-up is not driven, but R9 still receives
      run_frame(14, 0, 0, 0, 14'h2A5C, 14'h1234, 0, -99, 0, "R6");
      // R1 R2 R5: second frame drives the 14-bit word, non-delayed normal
      run_frame(14, 0, 0, 0, 14'h2A5C, 14'h0F0F, 1, -99, 0, "R2");
      run_frame(14, 0, 0, 0, 14'h3FFF, 14'h2001, 1, -99, 0, "R5");
      // R3: delayed timing
      run_frame(14, 1, 0, 0, 14'h1B36, 14'h3C71, 1, -99, 0, "R3");
      // R4: non-delayed reverse edges
      run_frame(14, 0, 1, 0, 14'h0ACE, 14'h2B95, 1, -99, 0, "R4");
      // R1: companded 8-bit word, high bits of tx_word ignored
      run_frame(8, 0, 0, 1, 14'h3F96, 14'h3FA5, 1, -99, 0, "R1");
      // R4: reverse select has no effect in delayed timing
      run_frame(8, 1, 1, 1, 14'h0169, 14'h00C3, 1, -99, 0, "R4");
      run_frame(8, 0, 1, 1, 14'h0055, 14'h00AA, 1, -99, 0, "R1");
      // R7: power down in the middle of a slot
      run_frame(14, 0, 0, 0, 14'h3FFF, 14'h1111, 1, 5, 1, "R7");
      @(negedge clk);
      pwr_up = 1'b1;
      run_frame(14, 0, 0, 0, 14'h3FFF, 14'h2222, 0, -99, 0, "R6");
      run_frame(14, 0, 0, 0, 14'h3FFF, 14'h3333, 1, -99, 0, "R6");
      // R8: bit clock stops in the middle of a slot
      run_frame(14, 1, 0, 0, 14'h3FFF, 14'h0444, 1, 6, 2, "R8");
      run_frame(14, 1, 0, 0, 14'h2AAA, 14'h0555, 0, -99, 0, "R8");
      run_frame(14, 1, 0, 0, 14'h2AAA, 14'h0666, 1, -99, 0, "R8");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule